// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block is a hardware master that loads a configuration image into a slave FPGA through the FPGA's serial slave configuration port. A single start pulse runs a fixed sequence. The block holds the target in reset, checks that the target's done pin is low, and releases reset. After a settling wait it sends a burst of dummy clocks with chip select high. It then lowers chip select and shifts out the image. Next it raises chip select and sends another burst of dummy clocks. Finally it checks that the target's done pin has gone high.

The image arrives as a byte stream with valid, ready and last. The block updates a CRC-32 on every byte it accepts. On success it raises a loaded flag and keeps the CRC of the image it sent. On failure it reports one of two error codes. It always leaves the target's reset and chip select lines high. Both delays and both dummy-clock counts are run-time inputs. The SPI clock comes from the system clock through a divide parameter.

Top module: `fcs_seq_top`

## Requirements
- R1: A start pulse while idle clears loaded, image_crc and err_code, and drives tgt_reset_n and tgt_cs_n low together in the next cycle.
- R2: tgt_reset_n stays low for max(reset_cycles,1) cycles and no SCLK pulse is issued during that time. If tgt_done reads high at the end of the hold, the run aborts with err_code 1 and issues no SCLK pulse.
- R3: After reset is released, tgt_cs_n stays low for max(config_cycles,1) cycles and then rises.
- R4: With tgt_cs_n high, 8*ceil(lead_clks/8) leading SCLK pulses are issued, with tgt_mosi low throughout.
- R5: Image bytes are sent with tgt_cs_n low in SPI mode 0, most significant bit first. SCLK idles low and tgt_mosi changes only while SCLK is low. Each SCLK half-period lasts SCLK_HALF clock cycles. A byte is taken on a cycle where img_valid and img_ready are both high. img_last marks the final byte.
- R6: After the final byte, tgt_cs_n rises and 8*ceil(trail_clks/8) trailing SCLK pulses are issued, with tgt_mosi low.
- R7: After the trailing pulses, tgt_done is sampled. If it is high, loaded becomes 1, image_crc holds the image CRC, and err_code is 0.
- R8: The CRC is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, final inversion) over all image bytes. For example, ASCII "123456789" gives 0xCBF43926.
- R9: Whenever busy is low, tgt_reset_n and tgt_cs_n are high and tgt_sclk and tgt_mosi are low.
- R10: A start pulse while busy has no effect on the running sequence.
- R11: done is high for exactly one cycle at the end of every run, and busy is already low in that cycle.
- R12: If tgt_done is low at the final check, err_code becomes 2, loaded stays 0 and image_crc stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse |
| reset_cycles | input | DLY_W | Reset hold length in clock cycles |
| config_cycles | input | DLY_W | Wait after reset release in clock cycles |
| lead_clks | input | CNT_W | Leading dummy clocks requested |
| trail_clks | input | CNT_W | Trailing dummy clocks requested |
| img_data | input | 8 | Image byte |
| img_valid | input | 1 | Image byte present |
| img_last | input | 1 | Image byte is the final one |
| img_ready | output | 1 | Block takes the byte this cycle |
| tgt_reset_n | output | 1 | Target reset, active low |
| tgt_cs_n | output | 1 | Target chip select, active low |
| tgt_sclk | output | 1 | SPI clock |
| tgt_mosi | output | 1 | SPI data to the target |
| tgt_done | input | 1 | Target configuration-done pin |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 none, 1 done high after reset, 2 done low at end |
| loaded | output | 1 | Last run succeeded |
| image_crc | output | 32 | CRC-32 of the last successful image |

## Verification
The bench builds the block with SCLK_HALF=1. At that setting each byte takes 16 clock cycles, which is short enough to run several complete loads, including dummy counts of 49 and 0 that are not multiples of eight. DLY_W and CNT_W keep their default values. Reset and configuration delays of 0, 1 and several cycles exercise the minimum-length rule. A behavioural target model holds tgt_done low, drives it high after the image, or holds it stuck high, so each error exit can be reached.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_CFG,
        ST_LEAD,
        ST_IMG,
        ST_TRAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE       = 2'd0,
        ERR_DONE_EARLY = 2'd1,
        ERR_DONE_LATE  = 2'd2
    } seq_err_t;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // One byte through the reflected CRC-32 register, low bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    // Dummy clock request rounded up to whole bytes.
    function automatic logic [31:0] clk_bytes(input logic [31:0] n);
        return (n + 32'd7) >> 3;
    endfunction

endpackage

// File: rtl/fcs_shifter.sv
module fcs_shifter #(
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] din,
    output logic       idle,
    output logic       sclk,
    output logic       mosi
);
    localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [DW-1:0] DIV_END = DW'(SCLK_HALF - 1);

    logic          active;
    logic [DW-1:0] div;
    logic [2:0]    bitn;
    logic [7:0]    sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            div    <= '0;
            bitn   <= '0;
            sr     <= '0;
            sclk   <= 1'b0;
        end else if (!active) begin
            sclk <= 1'b0;
            if (go) begin
                active <= 1'b1;
                sr     <= din;
                div    <= '0;
                bitn   <= '0;
            end
        end else if (div == DIV_END) begin
            div <= '0;
            if (!sclk) begin
                sclk <= 1'b1;
            end else begin
                sclk <= 1'b0;
                sr   <= {sr[6:0], 1'b0};
                if (bitn == 3'd7) active <= 1'b0;
                else              bitn   <= bitn + 3'd1;
            end
        end else begin
            div <= div + DW'(1);
        end
    end

    assign idle = !active;
    assign mosi = active & sr[7];

endmodule

// File: rtl/fcs_crc32.sv
module fcs_crc32 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  d,
    output logic [31:0] crc
);
    import fcs_pkg::*;

    logic [31:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= CRC_SEED;
        else if (en)    acc <= crc_step(acc, d);
    end

    assign crc = ~acc;

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl #(
    parameter int DLY_W = 16,
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DLY_W-1:0]  reset_cycles,
    input  logic [DLY_W-1:0]  config_cycles,
    input  logic [CNT_W-1:0]  lead_clks,
    input  logic [CNT_W-1:0]  trail_clks,
    input  logic              img_valid,
    input  logic              img_last,
    input  logic              tgt_done,
    input  logic              sh_idle,
    input  logic [31:0]       crc_in,
    output logic              img_ready,
    output logic              sh_go,
    output logic              sh_dummy,
    output logic              crc_clr,
    output logic              crc_en,
    output logic              creset_n,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output fcs_pkg::seq_err_t err,
    output logic              loaded,
    output logic [31:0]       crc_q
);
    import fcs_pkg::*;

    seq_state_t       state;
    logic [DLY_W-1:0] tmr;
    logic [CNT_W-1:0] rem;
    logic             last_seen;
    logic             tmr_end;
    logic             dummy_go;
    logic             accept;

    assign busy      = (state != ST_IDLE);
    assign tmr_end   = (tmr <= DLY_W'(1));
    assign img_ready = (state == ST_IMG) && sh_idle && !last_seen;
    assign accept    = img_ready && img_valid;
    assign dummy_go  = ((state == ST_LEAD) || (state == ST_TRAIL)) && sh_idle && (rem != '0);
    assign sh_go     = dummy_go || accept;
    assign sh_dummy  = (state != ST_IMG);
    assign crc_clr   = start && !busy;
    assign crc_en    = accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tmr       <= '0;
            rem       <= '0;
            last_seen <= 1'b0;
            creset_n  <= 1'b1;
            cs_n      <= 1'b1;
            done      <= 1'b0;
            err       <= ERR_NONE;
            loaded    <= 1'b0;
            crc_q     <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    loaded   <= 1'b0;
                    crc_q    <= '0;
                    err      <= ERR_NONE;
                    creset_n <= 1'b0;
                    cs_n     <= 1'b0;
                    tmr      <= reset_cycles;
                    state    <= ST_RST;
                end
                ST_RST: begin
                    if (!tmr_end) begin
                        tmr <= tmr - DLY_W'(1);
                    end else if (tgt_done) begin
                        err      <= ERR_DONE_EARLY;
                        creset_n <= 1'b1;
                        cs_n     <= 1'b1;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        creset_n <= 1'b1;
                        tmr      <= config_cycles;
                        state    <= ST_CFG;
                    end
                end
                ST_CFG: begin
                    if (!tmr_end) begin
                        tmr <= tmr - DLY_W'(1);
                    end else begin
                        cs_n  <= 1'b1;
                        rem   <= CNT_W'(clk_bytes(32'(lead_clks)));
                        state <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (dummy_go) begin
                        rem <= rem - CNT_W'(1);
                    end else if (sh_idle) begin
                        cs_n      <= 1'b0;
                        last_seen <= 1'b0;
                        state     <= ST_IMG;
                    end
                end
                ST_IMG: begin
                    if (accept && img_last) last_seen <= 1'b1;
                    if (last_seen && sh_idle) begin
                        cs_n  <= 1'b1;
                        rem   <= CNT_W'(clk_bytes(32'(trail_clks)));
                        state <= ST_TRAIL;
                    end
                end
                ST_TRAIL: begin
                    if (dummy_go) begin
                        rem <= rem - CNT_W'(1);
                    end else if (sh_idle) begin
                        creset_n <= 1'b1;
                        cs_n     <= 1'b1;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                        if (tgt_done) begin
                            loaded <= 1'b1;
                            crc_q  <= crc_in;
                        end else begin
                            err <= ERR_DONE_LATE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fcs_seq_top.sv
module fcs_seq_top #(
    parameter int SCLK_HALF = 2,
    parameter int DLY_W     = 16,
    parameter int CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DLY_W-1:0] reset_cycles,
    input  logic [DLY_W-1:0] config_cycles,
    input  logic [CNT_W-1:0] lead_clks,
    input  logic [CNT_W-1:0] trail_clks,
    input  logic [7:0]       img_data,
    input  logic             img_valid,
    input  logic             img_last,
    output logic             img_ready,
    output logic             tgt_reset_n,
    output logic             tgt_cs_n,
    output logic             tgt_sclk,
    output logic             tgt_mosi,
    input  logic             tgt_done,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err_code,
    output logic             loaded,
    output logic [31:0]      image_crc
);
    import fcs_pkg::*;

    logic        sh_go, sh_dummy, sh_idle;
    logic        crc_clr, crc_en;
    logic [31:0] crc_run;
    logic [7:0]  sh_data;
    seq_err_t    err;

    assign sh_data  = sh_dummy ? 8'h00 : img_data;
    assign err_code = err;

    fcs_ctrl #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .reset_cycles(reset_cycles), .config_cycles(config_cycles),
        .lead_clks(lead_clks), .trail_clks(trail_clks),
        .img_valid(img_valid), .img_last(img_last), .tgt_done(tgt_done),
        .sh_idle(sh_idle), .crc_in(crc_run),
        .img_ready(img_ready), .sh_go(sh_go), .sh_dummy(sh_dummy),
        .crc_clr(crc_clr), .crc_en(crc_en),
        .creset_n(tgt_reset_n), .cs_n(tgt_cs_n),
        .busy(busy), .done(done), .err(err),
        .loaded(loaded), .crc_q(image_crc)
    );

    fcs_shifter #(.SCLK_HALF(SCLK_HALF)) u_shift (
        .clk(clk), .rst(rst), .go(sh_go), .din(sh_data),
        .idle(sh_idle), .sclk(tgt_sclk), .mosi(tgt_mosi)
    );

    fcs_crc32 u_crc (
        .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en),
        .d(img_data), .crc(crc_run)
    );

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [1:0]  err_code,
    input logic        loaded,
    input logic [31:0] image_crc,
    input logic        img_ready,
    input logic        tgt_reset_n,
    input logic        tgt_cs_n,
    input logic        tgt_sclk,
    input logic        tgt_mosi
);
    assert_start_clears_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (!tgt_reset_n && !tgt_cs_n && !loaded && image_crc == 32'd0 && err_code == 2'd0));

    assert_no_clk_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
        !tgt_reset_n |-> !tgt_sclk);

    assert_dummy_mosi_low_R4: assert property (@(posedge clk) disable iff (rst)
        tgt_cs_n |-> !tgt_mosi);

    assert_mosi_stable_high_R5: assert property (@(posedge clk) disable iff (rst)
        (tgt_sclk && $past(tgt_sclk)) |-> $stable(tgt_mosi));

    assert_ready_in_window_R5: assert property (@(posedge clk) disable iff (rst)
        img_ready |-> (!tgt_cs_n && tgt_reset_n));

    assert_success_loaded_R7: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 2'd0) |-> loaded);

    assert_idle_pins_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tgt_reset_n && tgt_cs_n && !tgt_sclk && !tgt_mosi));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (busy || done));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_fail_no_crc_R12: assert property (@(posedge clk) disable iff (rst)
        (done && err_code != 2'd0) |-> (!loaded && image_crc == 32'd0));
endmodule

bind fcs_seq_top fcs_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .err_code(err_code), .loaded(loaded), .image_crc(image_crc),
    .img_ready(img_ready), .tgt_reset_n(tgt_reset_n), .tgt_cs_n(tgt_cs_n),
    .tgt_sclk(tgt_sclk), .tgt_mosi(tgt_mosi)
);

// File: tb/sim_fcs_seq_top.sv
module sim_fcs_seq_top;
    localparam int DLY_W = 16;
    localparam int CNT_W = 12;

    typedef struct packed {
        logic [11:0] lead;
        logic [11:0] trail;
        logic [7:0]  nbytes;
        logic [15:0] rcyc;
        logic [15:0] ccyc;
        logic [1:0]  mode;   // 0 target finishes, 1 done stuck high, 2 done never rises
        logic [7:0]  seed;   // 0 selects ASCII "123..."
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{12'd8,  12'd8,  8'd9, 16'd4, 16'd6, 2'd0, 8'd0},
        '{12'd0,  12'd0,  8'd1, 16'd1, 16'd1, 2'd0, 8'd5},
        '{12'd9,  12'd49, 8'd5, 16'd3, 16'd2, 2'd0, 8'd9},
        '{12'd8,  12'd8,  8'd3, 16'd2, 16'd2, 2'd1, 8'd4},
        '{12'd1,  12'd7,  8'd4, 16'd2, 16'd3, 2'd2, 8'd7},
        '{12'd16, 12'd0,  8'd6, 16'd0, 16'd0, 2'd0, 8'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [DLY_W-1:0] reset_cycles = '0, config_cycles = '0;
    logic [CNT_W-1:0] lead_clks = '0, trail_clks = '0;
    logic [7:0] img_data = '0;
    logic img_valid = 1'b0, img_last = 1'b0;
    logic img_ready, tgt_reset_n, tgt_cs_n, tgt_sclk, tgt_mosi;
    logic tgt_done = 1'b0;
    logic busy, done, loaded;
    logic [1:0] err_code;
    logic [31:0] image_crc;

    always #4 clk = ~clk;

    fcs_seq_top #(.SCLK_HALF(1), .DLY_W(DLY_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .reset_cycles(reset_cycles), .config_cycles(config_cycles),
        .lead_clks(lead_clks), .trail_clks(trail_clks),
        .img_data(img_data), .img_valid(img_valid), .img_last(img_last),
        .img_ready(img_ready), .tgt_reset_n(tgt_reset_n), .tgt_cs_n(tgt_cs_n),
        .tgt_sclk(tgt_sclk), .tgt_mosi(tgt_mosi), .tgt_done(tgt_done),
        .busy(busy), .done(done), .err_code(err_code),
        .loaded(loaded), .image_crc(image_crc)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] img_byte(input int seed, input int i);
        if (seed == 0) return 8'(8'h31 + i);
        return 8'(seed * 37 + i * 91 + (i >> 1) * 5);
    endfunction

    function automatic logic [31:0] ref_crc(input int seed, input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = img_byte(seed, i);
            for (int k = 0; k < 8; k++) begin
                logic fb = c[0] ^ b[k];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    // target / bus monitor
    int cur_mode = 0, cur_n = 0;
    int lead_seen = 0, trail_seen = 0, dummy_bad = 0;
    int rx_bits = 0, rx_n = 0;
    logic [7:0] rx_sh = '0;
    logic [7:0] rx_mem [16];
    int rlow = 0, cfgc = 0, donec = 0;
    bit cs_rose = 0;

    always @(posedge tgt_sclk) begin
        if (tgt_cs_n) begin
            if (rx_bits == 0) lead_seen++;
            else              trail_seen++;
            if (tgt_mosi) dummy_bad++;
        end else begin
            rx_sh = {rx_sh[6:0], tgt_mosi};
            rx_bits++;
            if (rx_bits % 8 == 0 && rx_n < 16) begin
                rx_mem[rx_n] = rx_sh;
                rx_n++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (!tgt_reset_n) rlow++;
            if (busy && tgt_reset_n && !tgt_cs_n && !cs_rose) cfgc++;
            if (busy && tgt_reset_n && tgt_cs_n) cs_rose = 1;
            if (done) donec++;
        end
        if (cur_mode == 1)                         tgt_done <= 1'b1;
        else if (cur_mode == 0 && rx_n == cur_n && cur_n != 0) tgt_done <= 1'b1;
        else                                       tgt_done <= 1'b0;
    end

    task automatic drive_stream(input int seed, input int n);
        for (int i = 0; i < n; i++) begin
            if (i % 3 == 1) begin
                img_valid = 1'b0;
                @(negedge clk);
            end
            img_data  = img_byte(seed, i);
            img_last  = (i == n - 1);
            img_valid = 1'b1;
            while (!img_ready) @(negedge clk);
            @(negedge clk);
        end
        img_valid = 1'b0;
        img_last  = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input bit poke);
        int guard;
        int rmin, cmin;
        int exp_err;
        bit fail_ok;
        rmin = (v.rcyc == 0) ? 1 : int'(v.rcyc);
        cmin = (v.ccyc == 0) ? 1 : int'(v.ccyc);
        @(negedge clk);
        lead_seen = 0; trail_seen = 0; dummy_bad = 0;
        rx_bits = 0; rx_n = 0; rlow = 0; cfgc = 0; donec = 0; cs_rose = 0;
        cur_mode = int'(v.mode); cur_n = int'(v.nbytes);
        reset_cycles = v.rcyc; config_cycles = v.ccyc;
        lead_clks = v.lead; trail_clks = v.trail;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!loaded && image_crc == 0 && err_code == 0 && !tgt_reset_n && !tgt_cs_n,
            "R1", {loaded, err_code, tgt_reset_n, tgt_cs_n}, 32'd0);
        if (poke) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (v.mode != 2'd1) drive_stream(int'(v.seed), int'(v.nbytes));
        guard = 0;
        while (donec == 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);

        chk(rlow == rmin, "R2", rlow, rmin);
        chk(donec == 1, "R11", donec, 1);
        chk(tgt_reset_n && tgt_cs_n && !busy, "R9", {tgt_reset_n, tgt_cs_n, busy}, 3'b110);
        exp_err = int'(v.mode);
        chk(int'(err_code) == exp_err, (v.mode == 2'd1) ? "R2" : (v.mode == 2'd2 ? "R12" : "R7"),
            err_code, exp_err);
        if (v.mode == 2'd1) begin
            chk(lead_seen == 0 && rx_bits == 0 && trail_seen == 0, "R2",
                lead_seen + rx_bits + trail_seen, 0);
            chk(!loaded && image_crc == 0, "R12", image_crc, 0);
        end else begin
            chk(cfgc == cmin, "R3", cfgc, cmin);
            chk(lead_seen == 8 * ((int'(v.lead) + 7) / 8), "R4", lead_seen, 8 * ((int'(v.lead) + 7) / 8));
            chk(trail_seen == 8 * ((int'(v.trail) + 7) / 8), "R6", trail_seen, 8 * ((int'(v.trail) + 7) / 8));
            chk(dummy_bad == 0, "R4", dummy_bad, 0);
            chk(rx_n == int'(v.nbytes) && rx_bits == 8 * int'(v.nbytes), "R5", rx_n, v.nbytes);
            for (int i = 0; i < int'(v.nbytes); i++)
                chk(rx_mem[i] == img_byte(int'(v.seed), i), "R5", rx_mem[i], img_byte(int'(v.seed), i));
            if (v.mode == 2'd0) begin
                chk(loaded, "R7", loaded, 1);
                chk(image_crc == ref_crc(int'(v.seed), int'(v.nbytes)), "R8",
                    image_crc, ref_crc(int'(v.seed), int'(v.nbytes)));
            end else begin
                fail_ok = !loaded && image_crc == 0;
                chk(fail_ok, "R12", {loaded, image_crc[30:0]}, 0);
            end
        end
        cur_mode = 0; cur_n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(tgt_reset_n && tgt_cs_n && !tgt_sclk && !tgt_mosi, "R9",
            {tgt_reset_n, tgt_cs_n, tgt_sclk, tgt_mosi}, 4'b1100);
        chk(!busy && !done && !loaded && err_code == 0 && image_crc == 0 && !img_ready, "R9",
            {busy, done, loaded, img_ready}, 0);

        for (int v = 0; v < NV; v++) run_vec(VECS[v], 1'b0);

        // known check value for ASCII digits 1..9 (R8)
        run_vec(VECS[0], 1'b0);
        chk(image_crc == 32'hCBF43926, "R8", image_crc, 32'hCBF43926);

        // start pulsed again mid-run must not restart the hold (R10)
        run_vec('{12'd8, 12'd8, 8'd2, 16'd6, 16'd2, 2'd0, 8'd11}, 1'b1);
        chk(rlow == 6 && donec == 1, "R10", rlow, 6);

        // failed run after a success clears the stored result (R12)
        run_vec(VECS[4], 1'b0);
        chk(!loaded && image_crc == 0, "R12", image_crc, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule